// File: doc/BRIEF.md
# XMODEM-1K Boot Image Receiver

This block loads a boot image that a host pushes over a serial link using XMODEM with CRC-16. It sits between an external UART (8 data bits, no parity, 1 stop bit, no flow control, 115200 baud) and a byte-wide memory write port. Received bytes arrive as a data byte with a one-cycle valid strobe. Handshake bytes for the host leave the block the same way, as a byte with a one-cycle valid strobe. Each payload byte that is accepted is written to memory at a fixed load address, and the address steps up by one for each byte. The image carries no header.

After reset the block asks the host to start by sending the CRC-mode ping at regular intervals. When a packet arrives, the block stages its payload in an internal buffer. The buffer is copied to memory only when the block-number complement and the CRC both match. Every packet then gets an ACK or a NAK. The block watches three time limits: the ping phase, the idle time between packets, and the gap between bytes of one packet. Each limit is derived from the `CLK_HZ` parameter. The block finishes in one of two ways: a one-cycle done pulse, or a timeout flag that stays high.

Top module: `xm_boot_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_valid`, `mem_we`, `done` and `timeout` are 0 and `byte_count` is 0.
- R2: From reset release the block sends ping 0x43 at the start of each interval of PING_CYC = CLK_HZ*3/10 cycles, ten pings in total. If no start byte arrives by the end of the tenth interval, `timeout` rises and no further ping is sent.
- R3: A packet is a start byte (SOH 0x01 for a 128-byte payload, STX 0x02 for a 1024-byte payload), then the block number, its ones' complement, the payload, and the CRC high byte then low byte. A valid packet with the expected number is answered with ACK 0x06.
- R4: Accepted payload bytes are written in order, one per `mem_we` cycle, starting at address 0x402F0400 and incrementing. `byte_count` equals the number of bytes written so far, and writes happen only after the packet's CRC has been checked.
- R5: The CRC is CRC-16 with polynomial 0x1021 and initial value 0, computed over the payload. On a mismatch the block answers NAK 0x15 and writes nothing.
- R6: If the complement byte does not match the block number, the block answers NAK and writes nothing.
- R7: A packet that repeats the last accepted block number is answered with ACK and is not written again. Any other unexpected number is answered with NAK.
- R8: The first expected block number is 1. Numbers wrap from 255 to 0.
- R9: Inside a packet, up to GAP_CYC = CLK_HZ/500 idle cycles between byte strobes are tolerated. After GAP_CYC+1 idle cycles the partial packet is dropped and NAK is sent.
- R10: Once the first packet has started, if no start byte or EOT arrives within IDLE_CYC = CLK_HZ*3 cycles after the last handshake byte, `timeout` rises.
- R11: EOT 0x04 between packets is answered with ACK together with a one-cycle `done` pulse. After that, all input is ignored.
- R12: The tenth consecutive NAK is sent and then `timeout` rises. An ACK resets the consecutive-NAK count.
- R13: Between packets, bytes other than SOH, STX and EOT are ignored and get no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Handshake byte strobe to the UART transmitter |
| tx_data | output | 8 | Handshake byte (0x43, 0x06 or 0x15) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle pulse when the transfer ends normally |
| timeout | output | 1 | Sticky failure flag (ping, idle or NAK limit) |
| byte_count | output | 32 | Total payload bytes written |

## Verification
The hardest case to reach is block-number wraparound. It needs 256 packets accepted in a row, so the bench runs a reduced-rate clock and streams back-to-back 128-byte packets numbered 1 through 255 and then 0. It then checks that a repeat of 0 is treated as a duplicate and that 1 is accepted as new. The inter-byte gap rule is checked at both sides of its boundary by pausing inside the payload for exactly GAP_CYC idle cycles and then for one cycle more. The NAK limit is reached with corrupted-CRC packets, both before and after an intervening ACK.

// File: rtl/xm_pkg.sv
package xm_pkg;
    localparam logic [7:0] XM_SOH  = 8'h01;
    localparam logic [7:0] XM_STX  = 8'h02;
    localparam logic [7:0] XM_EOT  = 8'h04;
    localparam logic [7:0] XM_ACK  = 8'h06;
    localparam logic [7:0] XM_NAK  = 8'h15;
    localparam logic [7:0] XM_PING = 8'h43;

    typedef enum logic [3:0] {
        ST_PING  = 4'd0,
        ST_WAIT  = 4'd1,
        ST_BLK   = 4'd2,
        ST_CMP   = 4'd3,
        ST_DATA  = 4'd4,
        ST_CRCH  = 4'd5,
        ST_CRCL  = 4'd6,
        ST_WRITE = 4'd7,
        ST_DONE  = 4'd8,
        ST_FAIL  = 4'd9
    } xm_state_e;
endpackage

// File: rtl/xm_crc16_step.sv
module xm_crc16_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in ^ {data_in, 8'h00};
        for (int i = 0; i < 8; i++) begin
            c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/xm_payload_buf.sv
module xm_payload_buf #(
    parameter int DEPTH = 1024,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/xm_boot_rx.sv
module xm_boot_rx
    import xm_pkg::*;
#(
    parameter int              CLK_HZ     = 48_000_000,
    parameter int              AW         = 32,
    parameter logic [AW-1:0]   LOAD_ADDR  = 32'h402F_0400,
    parameter int              PING_COUNT = 10,
    parameter int              NAK_LIMIT  = 10,
    parameter int              SMALL_LEN  = 128,
    parameter int              BIG_LEN    = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          done,
    output logic          timeout,
    output logic [31:0]   byte_count
);
    localparam int PING_CYC = (CLK_HZ * 3) / 10;
    localparam int IDLE_CYC = CLK_HZ * 3;
    localparam int GAP_CYC  = CLK_HZ / 500;
    localparam int TW       = $clog2(IDLE_CYC + 1);
    localparam int IW       = $clog2(BIG_LEN);
    localparam int PW       = $clog2(PING_COUNT + 1);
    localparam int NW       = $clog2(NAK_LIMIT + 1);

    typedef struct packed {
        xm_state_e     st;
        logic [TW-1:0] tmr;
        logic [PW-1:0] pings;
        logic [NW-1:0] naks;
        logic [7:0]    exp_blk;
        logic [7:0]    blk;
        logic          cmp_ok;
        logic          big;
        logic          got_any;
        logic [IW-1:0] idx;
        logic [15:0]   crc;
        logic [7:0]    crc_hi;
        logic          tx_v;
        logic [7:0]    tx_b;
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    wdata;
        logic [31:0]   count;
        logic          done;
        logic          tmo;
    } regs_t;

    regs_t r_q, r_d;

    logic [15:0]   crc_next;
    logic [7:0]    buf_rd;
    logic          buf_we;
    logic          do_ack, do_nak;
    logic          is_start;
    logic [IW-1:0] last_idx;

    xm_crc16_step #(.POLY(16'h1021)) u_crc (
        .crc_in  (r_q.crc),
        .data_in (rx_data),
        .crc_out (crc_next)
    );

    xm_payload_buf #(.DEPTH(BIG_LEN)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (r_q.idx),
        .wr_data (rx_data),
        .rd_addr (r_q.idx),
        .rd_data (buf_rd)
    );

    assign is_start = (rx_data == XM_SOH) || (rx_data == XM_STX);
    assign last_idx = r_q.big ? IW'(BIG_LEN - 1) : IW'(SMALL_LEN - 1);

    always_comb begin
        r_d      = r_q;
        r_d.tx_v = 1'b0;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;
        do_ack   = 1'b0;
        do_nak   = 1'b0;
        buf_we   = 1'b0;

        unique case (r_q.st)
            ST_PING: begin
                r_d.tmr = r_q.tmr + 1'b1;
                if (r_q.tmr == '0) begin
                    r_d.tx_v  = 1'b1;
                    r_d.tx_b  = XM_PING;
                    r_d.pings = r_q.pings + 1'b1;
                end
                if (rx_valid && is_start) begin
                    r_d.st  = ST_BLK;
                    r_d.big = (rx_data == XM_STX);
                    r_d.tmr = '0;
                end else if (r_q.tmr == TW'(PING_CYC - 1)) begin
                    r_d.tmr = '0;
                    if (r_q.pings == PW'(PING_COUNT)) begin
                        r_d.st  = ST_FAIL;
                        r_d.tmo = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                r_d.tmr = r_q.tmr + 1'b1;
                if (rx_valid && is_start) begin
                    r_d.st  = ST_BLK;
                    r_d.big = (rx_data == XM_STX);
                    r_d.tmr = '0;
                end else if (rx_valid && rx_data == XM_EOT) begin
                    do_ack   = 1'b1;
                    r_d.st   = ST_DONE;
                    r_d.done = 1'b1;
                end else if (r_q.tmr == TW'(IDLE_CYC - 1)) begin
                    r_d.st  = ST_FAIL;
                    r_d.tmo = 1'b1;
                end
            end
            ST_BLK, ST_CMP, ST_DATA, ST_CRCH, ST_CRCL: begin
                if (rx_valid) begin
                    r_d.tmr = '0;
                    case (r_q.st)
                        ST_BLK: begin
                            r_d.blk = rx_data;
                            r_d.st  = ST_CMP;
                        end
                        ST_CMP: begin
                            r_d.cmp_ok = (rx_data == ~r_q.blk);
                            r_d.idx    = '0;
                            r_d.crc    = '0;
                            r_d.st     = ST_DATA;
                        end
                        ST_DATA: begin
                            buf_we  = 1'b1;
                            r_d.crc = crc_next;
                            r_d.idx = r_q.idx + 1'b1;
                            if (r_q.idx == last_idx) r_d.st = ST_CRCH;
                        end
                        ST_CRCH: begin
                            r_d.crc_hi = rx_data;
                            r_d.st     = ST_CRCL;
                        end
                        default: begin
                            if (!r_q.cmp_ok || ({r_q.crc_hi, rx_data} != r_q.crc)) begin
                                do_nak = 1'b1;
                            end else if (r_q.blk == r_q.exp_blk) begin
                                r_d.st  = ST_WRITE;
                                r_d.idx = '0;
                            end else if (r_q.got_any && (r_q.blk == r_q.exp_blk - 8'd1)) begin
                                do_ack = 1'b1;
                                r_d.st = ST_WAIT;
                            end else begin
                                do_nak = 1'b1;
                            end
                        end
                    endcase
                end else if (r_q.tmr == TW'(GAP_CYC)) begin
                    do_nak = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_WRITE: begin
                r_d.we    = 1'b1;
                r_d.addr  = LOAD_ADDR + AW'(r_q.count);
                r_d.wdata = buf_rd;
                r_d.count = r_q.count + 32'd1;
                r_d.idx   = r_q.idx + 1'b1;
                if (r_q.idx == last_idx) begin
                    do_ack      = 1'b1;
                    r_d.st      = ST_WAIT;
                    r_d.exp_blk = r_q.exp_blk + 8'd1;
                    r_d.got_any = 1'b1;
                end
            end
            ST_DONE, ST_FAIL: begin
            end
            default: begin
                r_d.st = ST_FAIL;
            end
        endcase

        if (do_ack) begin
            r_d.tx_v = 1'b1;
            r_d.tx_b = XM_ACK;
            r_d.naks = '0;
            r_d.tmr  = '0;
        end
        if (do_nak) begin
            r_d.tx_v = 1'b1;
            r_d.tx_b = XM_NAK;
            r_d.tmr  = '0;
            r_d.st   = ST_WAIT;
            if (r_q.naks == NW'(NAK_LIMIT - 1)) begin
                r_d.st  = ST_FAIL;
                r_d.tmo = 1'b1;
            end else begin
                r_d.naks = r_q.naks + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_PING;
            r_q.exp_blk <= 8'd1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid   = r_q.tx_v;
    assign tx_data    = r_q.tx_b;
    assign mem_we     = r_q.we;
    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.wdata;
    assign done       = r_q.done;
    assign timeout    = r_q.tmo;
    assign byte_count = r_q.count;
endmodule

// File: rtl/xm_boot_rx_chk.sv
module xm_boot_rx_chk #(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] LOAD_ADDR = 32'h402F_0400
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          timeout,
    input logic [31:0]   byte_count
);
    logic done_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) done_seen <= 1'b0;
        else if (done) done_seen <= 1'b1;
    end

    // R4
    write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (byte_count == 32'(mem_addr - LOAD_ADDR) + 32'd1));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (byte_count == $past(byte_count)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> (!tx_valid && !mem_we));

    // R12
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    // R11
    end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R3
    tx_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == 8'h43 || tx_data == 8'h06 || tx_data == 8'h15));

    // R4
    no_write_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timeout) |-> !mem_we);
endmodule

bind xm_boot_rx xm_boot_rx_chk #(.AW(AW), .LOAD_ADDR(LOAD_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .done       (done),
    .timeout    (timeout),
    .byte_count (byte_count)
);

// File: tb/tb_xm_boot_rx.sv
`timescale 1ns/1ps
module tb_xm_boot_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HZ    = 10_000;
    localparam int PING  = HZ * 3 / 10;
    localparam int IDLE  = HZ * 3;
    localparam int GAP   = HZ / 500;
    localparam logic [31:0] LOAD = 32'h402F_0400;
    localparam int MSZ   = 2560;

    // {big, flaw[1:0], writes, blk[7:0], reply[7:0]}; flaw 1 = bad CRC, 2 = bad complement
    localparam logic [19:0] VEC [0:7] = '{
        {1'b0, 2'd0, 1'b1, 8'd1, 8'h06},
        {1'b1, 2'd0, 1'b1, 8'd2, 8'h06},
        {1'b0, 2'd1, 1'b0, 8'd3, 8'h15},
        {1'b0, 2'd0, 1'b1, 8'd3, 8'h06},
        {1'b0, 2'd0, 1'b0, 8'd3, 8'h06},
        {1'b1, 2'd2, 1'b0, 8'd4, 8'h15},
        {1'b0, 2'd0, 1'b0, 8'd5, 8'h15},
        {1'b1, 2'd0, 1'b1, 8'd4, 8'h06}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        rx_valid = 0;
    logic [7:0]  rx_data = 0;
    logic        tx_valid, mem_we, done, timeout;
    logic [7:0]  tx_data, mem_wdata;
    logic [31:0] mem_addr, byte_count;

    int checks = 0, errors = 0;
    int tx_cnt = 0, ping_cnt = 0, wr_cnt = 0, done_cnt = 0, addr_err = 0;
    int cyc = 0;
    logic [7:0] last_tx = 0;
    logic [7:0] model [MSZ];

    xm_boot_rx #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
        .timeout(timeout), .byte_count(byte_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tx_valid) begin
            tx_cnt  <= tx_cnt + 1;
            last_tx <= tx_data;
            if (tx_data == 8'h43) ping_cnt <= ping_cnt + 1;
        end
        if (mem_we) begin
            if (mem_addr != LOAD + 32'(wr_cnt)) addr_err <= addr_err + 1;
            if (wr_cnt < MSZ) model[wr_cnt] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    function automatic logic [7:0] pat(input logic [7:0] blk, input int i);
        return 8'(int'(blk) * 7 + i * 3 + (i >> 7));
    endfunction

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int b = 7; b >= 0; b--) begin
            logic fb = r[15] ^ d[b];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; rx_valid = 0;
        repeat (4) @(negedge clk);
        tx_cnt = 0; ping_cnt = 0; wr_cnt = 0; done_cnt = 0; addr_err = 0;
        rst_n = 1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
    endtask

    task automatic release_rx();
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic send_pkt(input bit big, input logic [7:0] blk, input int flaw,
                            input int gap_at, input int gap_len);
        int n;
        logic [15:0] c;
        logic [7:0] cmp;
        n = big ? 1024 : 128;
        c = 16'h0000;
        for (int i = 0; i < n; i++) c = crc_upd(c, pat(blk, i));
        if (flaw == 1) c = c ^ 16'h0001;
        cmp = ~blk;
        if (flaw == 2) cmp = cmp ^ 8'h01;
        send_byte(big ? 8'h02 : 8'h01);
        send_byte(blk);
        send_byte(cmp);
        for (int i = 0; i < n; i++) begin
            if (i == gap_at) begin
                @(negedge clk);
                rx_valid = 0;
                repeat (gap_len - 1) @(negedge clk);
                if (gap_len > GAP) return;
            end
            send_byte(pat(blk, i));
        end
        send_byte(c[15:8]);
        send_byte(c[7:0]);
        release_rx();
    endtask

    task automatic wait_reply(input int base, input int lim, output logic [7:0] b, output bit got);
        got = 0; b = 8'h00;
        for (int k = 0; k < lim; k++) begin
            @(posedge clk);
            if (tx_cnt > base) begin
                got = 1; b = last_tx;
                return;
            end
        end
    endtask

    initial begin : watchdog
        wait (cyc >= 195_000);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 195_000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rb;
        bit got;
        int base, wbase, t0, bad;

        // ---- R1 reset state ----
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_we && !done && !timeout && byte_count == 0, "R1",
            "outputs in reset", {tx_valid, mem_we, done, timeout}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!mem_we && !done && !timeout && byte_count == 0, "R1", "after release", byte_count, 0);

        // ---- R2 ping phase ending in timeout ----
        do_reset();
        t0 = cyc;
        wait (cyc >= t0 + 3);
        @(negedge clk);
        chk(ping_cnt == 1 && last_tx == 8'h43, "R2", "first ping", last_tx, 8'h43);
        wait (cyc >= t0 + 10 * PING - 10);
        @(negedge clk);
        chk(timeout == 0, "R2", "timeout before window end", timeout, 0);
        chk(ping_cnt == 10, "R2", "ping count", ping_cnt, 10);
        wait (cyc >= t0 + 10 * PING + 10);
        @(negedge clk);
        chk(timeout == 1, "R2", "timeout after window end", timeout, 1);
        wait (cyc >= t0 + 10 * PING + 2 * PING);
        @(negedge clk);
        chk(ping_cnt == 10, "R2", "no ping after timeout", ping_cnt, 10);

        // ---- vector table: R3 R4 R5 R6 R7 ----
        do_reset();
        wait_reply(0, 50, rb, got);
        for (int v = 0; v < 8; v++) begin
            logic [19:0] e;
            int len;
            e = VEC[v];
            len = e[19] ? 1024 : 128;
            base = tx_cnt; wbase = wr_cnt;
            send_pkt(e[19], e[15:8], int'(e[18:17]), -1, 0);
            wait_reply(base, 2000, rb, got);
            chk(got && rb == e[7:0], "R3 R5 R6 R7", $sformatf("vector %0d reply", v), rb, e[7:0]);
            chk(wr_cnt - wbase == (e[16] ? len : 0), "R4 R7", $sformatf("vector %0d writes", v),
                wr_cnt - wbase, e[16] ? len : 0);
        end
        chk(byte_count == 2304, "R4", "byte_count", byte_count, 2304);
        chk(addr_err == 0, "R4", "address sequence errors", addr_err, 0);
        bad = 0;
        for (int i = 0; i < 128; i++)  if (model[i] != pat(8'd1, i)) bad++;
        for (int i = 0; i < 1024; i++) if (model[128 + i] != pat(8'd2, i)) bad++;
        for (int i = 0; i < 128; i++)  if (model[1152 + i] != pat(8'd3, i)) bad++;
        for (int i = 0; i < 1024; i++) if (model[1280 + i] != pat(8'd4, i)) bad++;
        chk(bad == 0, "R4", "memory contents mismatches", bad, 0);

        // ---- R11 EOT ----
        base = tx_cnt;
        send_byte(8'h04);
        release_rx();
        wait_reply(base, 50, rb, got);
        chk(got && rb == 8'h06, "R11", "EOT reply", rb, 8'h06);
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
        base = tx_cnt; wbase = wr_cnt;
        send_pkt(1'b0, 8'd5, 0, -1, 0);
        repeat (400) @(negedge clk);
        chk(tx_cnt == base && wr_cnt == wbase, "R11", "input ignored after done",
            tx_cnt - base, 0);

        // ---- R9 gap boundary, R13 ignored bytes, R10 idle timeout ----
        do_reset();
        wait_reply(0, 50, rb, got);
        base = tx_cnt; wbase = wr_cnt;
        send_pkt(1'b0, 8'd1, 0, 5, GAP);
        wait_reply(base, 600, rb, got);
        chk(got && rb == 8'h06, "R9", "gap of GAP cycles accepted", rb, 8'h06);
        chk(wr_cnt - wbase == 128, "R9", "writes after tolerated gap", wr_cnt - wbase, 128);
        base = tx_cnt; wbase = wr_cnt;
        send_pkt(1'b0, 8'd2, 0, 5, GAP + 1);
        wait_reply(base, 100, rb, got);
        chk(got && rb == 8'h15, "R9", "gap of GAP+1 cycles rejected", rb, 8'h15);
        chk(wr_cnt == wbase, "R9", "no writes after rejected gap", wr_cnt - wbase, 0);
        base = tx_cnt;
        send_pkt(1'b0, 8'd2, 0, -1, 0);
        wait_reply(base, 600, rb, got);
        chk(got && rb == 8'h06, "R9", "resend after gap", rb, 8'h06);
        t0 = cyc;
        base = tx_cnt;
        send_byte(8'h55);
        send_byte(8'h43);
        release_rx();
        repeat (60) @(negedge clk);
        chk(tx_cnt == base, "R13", "stray bytes unanswered", tx_cnt - base, 0);
        wait (cyc >= t0 + IDLE - 10);
        @(negedge clk);
        chk(timeout == 0, "R10", "no timeout before idle limit", timeout, 0);
        wait (cyc >= t0 + IDLE + 10);
        @(negedge clk);
        chk(timeout == 1, "R10", "timeout after idle limit", timeout, 1);

        // ---- R12 NAK limit with an intervening ACK ----
        do_reset();
        wait_reply(0, 50, rb, got);
        for (int k = 0; k < 5; k++) begin
            base = tx_cnt;
            send_pkt(1'b0, 8'd1, 1, -1, 0);
            wait_reply(base, 100, rb, got);
        end
        base = tx_cnt;
        send_pkt(1'b0, 8'd1, 0, -1, 0);
        wait_reply(base, 600, rb, got);
        chk(got && rb == 8'h06 && timeout == 0, "R12", "ACK after 5 NAKs", rb, 8'h06);
        for (int k = 0; k < 9; k++) begin
            base = tx_cnt;
            send_pkt(1'b0, 8'd2, 1, -1, 0);
            wait_reply(base, 100, rb, got);
        end
        @(negedge clk);
        chk(got && rb == 8'h15 && timeout == 0, "R12", "nine NAKs no timeout", timeout, 0);
        base = tx_cnt;
        send_pkt(1'b0, 8'd2, 1, -1, 0);
        wait_reply(base, 100, rb, got);
        repeat (2) @(negedge clk);
        chk(got && rb == 8'h15, "R12", "tenth NAK sent", rb, 8'h15);
        chk(timeout == 1, "R12", "timeout after tenth NAK", timeout, 1);

        // ---- R8 block number wrap ----
        do_reset();
        wait_reply(0, 50, rb, got);
        bad = 0;
        for (int k = 1; k <= 256; k++) begin
            base = tx_cnt;
            send_pkt(1'b0, 8'(k), 0, -1, 0);
            wait_reply(base, 600, rb, got);
            if (!got || rb != 8'h06) bad++;
        end
        chk(bad == 0, "R8", "packets 1..255,0 acked", bad, 0);
        chk(byte_count == 32768, "R8", "byte_count after wrap", byte_count, 32768);
        base = tx_cnt; wbase = wr_cnt;
        send_pkt(1'b0, 8'd0, 0, -1, 0);
        wait_reply(base, 600, rb, got);
        chk(got && rb == 8'h06 && wr_cnt == wbase, "R8", "block 0 repeat is duplicate",
            wr_cnt - wbase, 0);
        base = tx_cnt; wbase = wr_cnt;
        send_pkt(1'b0, 8'd1, 0, -1, 0);
        wait_reply(base, 600, rb, got);
        chk(got && rb == 8'h06 && wr_cnt - wbase == 128, "R8", "block 1 after wrap written",
            wr_cnt - wbase, 128);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule